// File: doc/BRIEF.md
# GPIO Port with Interrupt Triggers

A register-mapped general-purpose I/O port on a simple 32-bit bus: an address, a write strobe, write data, and combinational read data. Each pin has its own direction bit and output data bit. The four lowest pins also serve as external interrupt inputs. Each interrupt line has its own enable and a 3-bit trigger selector, which picks active-low level, active-high level, rising edge, falling edge or both-edge detection. Two further pins can be taken over by external timer outputs.

Pad inputs pass through a two-flop synchronizer. Level interrupts follow the synchronized pin. Edge interrupts latch a pending flag, which stays set until software writes a 1 to the matching bit of the data register. The timers are outside this block; their outputs arrive on `timer_i`.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers sit at byte offsets 0x00 (direction), 0x04 (control) and 0x08 (data). Any other address reads as zero, and writes to it change nothing.
- R2: Direction bit p = 1 makes pin p an output (`pin_oe_o[p]` = 1) driving data bit p on `pin_o[p]`. Direction bit p = 0 makes pin p an input. The direction register reads back what was written.
- R3: Reading the data register returns, in bit p, the driven value for an output pin and the synchronized pad level for an input pin. A pad change shows up in the read after two clock edges.
- R4: In the control register, interrupt line k (0..3) has its enable at bit 4k+3 and its trigger mode at bits 4k+2..4k. Bits 31..18 read as zero.
- R5: Trigger mode 0 (active-low level) asserts `irq_o[k]` while the synchronized pin k is 0. Mode 1 (active-high level) asserts it while that pin is 1.
- R6: Trigger modes 2 (rising), 4 (falling) and 6 (either edge) set a pending flag on the selected transition of synchronized pin k. `irq_o[k]` shows that flag while the line is enabled.
- R7: A data-register write with bit k = 1 clears pending flag k. If an edge is detected in the same cycle, the flag stays set.
- R8: Trigger modes 3, 5 and 7 never assert an interrupt or set a pending flag. A disabled line never asserts `irq_o[k]` and never sets its pending flag.
- R9: Control bit 16 makes pin 4 an output driven by `timer_i[0]`, and control bit 17 does the same for pin 5 with `timer_i[1]`. Both override the direction and data registers.
- R10: After reset every register is zero: all pins are inputs, no interrupt is asserted and no timer is routed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address of register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pin_i | input | 16 | Pad input levels |
| pin_o | output | 16 | Pad output values |
| pin_oe_o | output | 16 | Pad output enables |
| timer_i | input | 2 | Timer 0/1 outputs |
| irq_o | output | 4 | Interrupt requests |

## Verification
Two events can land on the same clock edge: an edge-mode pending flag being set by a new transition, and that flag being cleared by a data-register write. The bench provokes this by timing a pad transition so that its detection cycle coincides with the clearing write. It then expects the interrupt to remain asserted. A second run places the write one cycle later and expects the interrupt to drop. Random trials over all eight trigger codes, both enable states and all pin transitions are judged against a bench function of the trigger rules.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFS_DIR  = 'h0;
  localparam int OFS_CTRL = 'h4;
  localparam int OFS_DATA = 'h8;

  localparam logic [2:0] TRIG_LVL_LO = 3'd0;
  localparam logic [2:0] TRIG_LVL_HI = 3'd1;
  localparam logic [2:0] TRIG_RISE   = 3'd2;
  localparam logic [2:0] TRIG_FALL   = 3'd4;
  localparam logic [2:0] TRIG_BOTH   = 3'd6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_trig_unit.sv
module gpio_trig_unit
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  input  logic       lvl_i,
  input  logic       clr_i,
  output logic       irq_o
);
  logic prev_q, pend_q;
  logic rise, fall, hit, edge_mode;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    hit       = 1'b0;
    edge_mode = 1'b0;
    case (mode_i)
      TRIG_RISE: begin hit = rise;        edge_mode = 1'b1; end
      TRIG_FALL: begin hit = fall;        edge_mode = 1'b1; end
      TRIG_BOTH: begin hit = rise | fall; edge_mode = 1'b1; end
      default:   ;
    endcase
    hit = hit & en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // a fresh edge wins over a clear in the same cycle
      if (hit)        pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  always_comb begin
    irq_o = 1'b0;
    if (en_i) begin
      if (mode_i == TRIG_LVL_LO)      irq_o = ~lvl_i;
      else if (mode_i == TRIG_LVL_HI) irq_o = lvl_i;
      else if (edge_mode)             irq_o = pend_q;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NUM_PINS = 16,
  parameter int T0_PIN   = 4,
  parameter int T1_PIN   = 5
) (
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] data_i,
  input  logic [1:0]          tmr_en_i,
  input  logic [1:0]          timer_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] oe_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == T0_PIN) begin : g_t0
      assign pin_o[p] = tmr_en_i[0] ? timer_i[0] : data_i[p];
      assign oe_o[p]  = tmr_en_i[0] | dir_i[p];
    end else if (p == T1_PIN) begin : g_t1
      assign pin_o[p] = tmr_en_i[1] ? timer_i[1] : data_i[p];
      assign oe_o[p]  = tmr_en_i[1] | dir_i[p];
    end else begin : g_plain
      assign pin_o[p] = data_i[p];
      assign oe_o[p]  = dir_i[p];
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_IRQ  = 4,
  parameter int ADDR_W   = 4,
  parameter int T0_PIN   = 4,
  parameter int T1_PIN   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  input  logic [1:0]          timer_i,
  output logic [NUM_IRQ-1:0]  irq_o
);
  localparam int CTRL_W = 4 * NUM_IRQ + 2;

  logic [NUM_PINS-1:0] dir_q, data_q, pin_sync, pin_rd;
  logic [CTRL_W-1:0]   ctrl_q;
  logic                sel_dir, sel_ctrl, sel_data;

  assign sel_dir  = addr_i == ADDR_W'(OFS_DIR);
  assign sel_ctrl = addr_i == ADDR_W'(OFS_CTRL);
  assign sel_data = addr_i == ADDR_W'(OFS_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      ctrl_q <= '0;
      data_q <= '0;
    end else if (we_i) begin
      if (sel_dir)  dir_q  <= wdata_i[NUM_PINS-1:0];
      if (sel_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (sel_data) data_q <= wdata_i[NUM_PINS-1:0];
    end
  end

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_pin_mux #(
    .NUM_PINS(NUM_PINS), .T0_PIN(T0_PIN), .T1_PIN(T1_PIN)
  ) u_mux (
    .dir_i   (dir_q),
    .data_i  (data_q),
    .tmr_en_i(ctrl_q[CTRL_W-1 -: 2]),
    .timer_i (timer_i),
    .pin_o   (pin_o),
    .oe_o    (pin_oe_o)
  );

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    gpio_trig_unit u_trig (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ctrl_q[4*k+3]),
      .mode_i(ctrl_q[4*k +: 3]),
      .lvl_i (pin_sync[k]),
      .clr_i (we_i & sel_data & wdata_i[k]),
      .irq_o (irq_o[k])
    );
  end

  assign pin_rd = (pin_oe_o & pin_o) | (~pin_oe_o & pin_sync);

  always_comb begin
    rdata_o = '0;
    if (sel_dir)       rdata_o[NUM_PINS-1:0] = dir_q;
    else if (sel_ctrl) rdata_o[CTRL_W-1:0]   = ctrl_q;
    else if (sel_data) rdata_o[NUM_PINS-1:0] = pin_rd;
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NUM_PINS = 16,
  parameter int NUM_IRQ  = 4,
  parameter int ADDR_W   = 4,
  parameter int T0_PIN   = 4,
  parameter int T1_PIN   = 5,
  parameter int CTRL_W   = 4 * NUM_IRQ + 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [1:0]          timer_i,
  input logic [NUM_IRQ-1:0]  irq_o,
  input logic [CTRL_W-1:0]   ctrl_q,
  input logic [NUM_PINS-1:0] pin_sync
);
  p_dir_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(0)) |=>
      (addr_i != ADDR_W'(0) || rdata_o[NUM_PINS-1:0] == $past(wdata_i[NUM_PINS-1:0])));

  p_ctrl_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(4)) |-> rdata_o[31:CTRL_W] == '0);

  p_timer0_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTRL_W-2] |-> (pin_oe_o[T0_PIN] && pin_o[T0_PIN] == timer_i[0]));

  p_timer1_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTRL_W-1] |-> (pin_oe_o[T1_PIN] && pin_o[T1_PIN] == timer_i[1]));

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_k
    p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_q[4*k+3] |-> !irq_o[k]);

    p_unused_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[4*k] && ctrl_q[4*k+1]) || (ctrl_q[4*k] && ctrl_q[4*k+2])
        |-> !irq_o[k]);

    p_level_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[4*k+3] && ctrl_q[4*k +: 3] == 3'd1) |-> irq_o[k] == pin_sync[k]);

    p_level_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[4*k+3] && ctrl_q[4*k +: 3] == 3'd0) |-> irq_o[k] == !pin_sync[k]);
  end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W),
  .T0_PIN(T0_PIN), .T1_PIN(T1_PIN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .timer_i (timer_i),
  .irq_o   (irq_o),
  .ctrl_q  (ctrl_q),
  .pin_sync(pin_sync)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic [1:0]  tmr = '0;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  logic [NP-1:0] dir_m = '0, data_m = '0;
  logic [31:0]   ctrl_m = '0;

  always #5 clk = ~clk;

  gpio_irq_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .timer_i(tmr), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 4'h0) dir_m = d[NP-1:0];
    if (a == 4'h4) ctrl_m = d & 32'h3FFFF;
    if (a == 4'h8) data_m = d[NP-1:0];
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] exp_oe(logic [NP-1:0] dm, logic [31:0] c);
    logic [NP-1:0] o = dm;
    if (c[16]) o[4] = 1'b1;
    if (c[17]) o[5] = 1'b1;
    return o;
  endfunction

  function automatic logic [NP-1:0] exp_out(logic [NP-1:0] d, logic [31:0] c, logic [1:0] t);
    logic [NP-1:0] o = d;
    if (c[16]) o[4] = t[0];
    if (c[17]) o[5] = t[1];
    return o;
  endfunction

  // R5/R6/R8 reference: irq after steady v0 then transition to v1
  function automatic logic exp_irq(logic [2:0] m, logic en, logic v0, logic v1);
    if (!en) return 1'b0;
    case (m)
      3'd0: return !v1;
      3'd1: return v1;
      3'd2: return !v0 && v1;
      3'd4: return v0 && !v1;
      3'd6: return v0 != v1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_1234));
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);

    // R10 reset state
    rd(4'h0, r); chk("R10 dir", r, 0);
    rd(4'h4, r); chk("R10 ctrl", r, 0);
    rd(4'h8, r); chk("R10 data", r, 0);
    chk("R10 oe", 32'(pin_oe), 0);
    chk("R10 irq", 32'(irq), 0);

    // R1 unmapped write ignored, reads zero
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, r); chk("R1 unmapped read", r, 0);
    rd(4'h0, r); chk("R1 dir untouched", r, 0);
    rd(4'h4, r); chk("R1 ctrl untouched", r, 0);
    chk("R1 oe untouched", 32'(pin_oe), 0);

    // R4 ctrl upper bits read zero
    wr(4'h4, 32'hFFFF_FFF0);
    rd(4'h4, r); chk("R4 ctrl mask", r, 32'h0003_FFF0);
    wr(4'h4, 32'h0);

    // R2/R3/R9 random I/O trials
    for (int i = 0; i < 40; i++) begin
      logic [NP-1:0] e_oe, e_out;
      wr(4'h0, $urandom);
      wr(4'h8, $urandom & 32'hFFF0);
      wr(4'h4, $urandom & 32'h0003_0000);
      tmr = 2'($urandom);
      pin_in = NP'($urandom);
      cyc(3);
      e_oe  = exp_oe(dir_m, ctrl_m);
      e_out = exp_out(data_m, ctrl_m, tmr);
      chk("R2 oe", 32'(pin_oe), 32'(e_oe));
      chk("R2 out", 32'(pin_out & e_oe), 32'(e_out & e_oe));
      chk("R9 timer pins", 32'(pin_out[5:4]), 32'(e_out[5:4]));
      rd(4'h0, r); chk("R2 dir readback", r, 32'(dir_m));
      rd(4'h8, r); chk("R3 data read", r, 32'((e_oe & e_out) | (~e_oe & pin_in)));
    end

    // R3 two-edge latency on input read
    wr(4'h0, 32'h0); wr(4'h4, 32'h0);
    pin_in = '0; cyc(3);
    pin_in[9] = 1'b1;
    @(negedge clk); rd(4'h8, r); chk("R3 lat 1 edge", 32'(r[9]), 0);
    @(negedge clk); rd(4'h8, r); chk("R3 lat 2 edges", 32'(r[9]), 1);

    // R5/R6/R8 random trigger trials on all lines
    for (int i = 0; i < 80; i++) begin
      int k = int'($urandom % 4);
      logic [2:0] m = 3'($urandom);
      logic en = 1'($urandom);
      logic v0 = 1'($urandom), v1 = 1'($urandom);
      pin_in = '0; pin_in[k] = v0;
      wr(4'h4, 32'({en, m}) << (4*k));
      cyc(4);
      wr(4'h8, 32'hF);
      pin_in[k] = v1;
      cyc(4);
      chk($sformatf("R6/R5/R8 line%0d mode%0d en%0d %0d->%0d", k, m, en, v0, v1),
          32'(irq[k]), 32'(exp_irq(m, en, v0, v1)));
    end

    // R7 clear: pending drops after write, stays without
    wr(4'h4, 32'h0000_000A);         // line0 enabled, rising
    pin_in[0] = 1'b0; cyc(4); wr(4'h8, 32'h1);
    pin_in[0] = 1'b1; cyc(4);
    chk("R7 pending set", 32'(irq[0]), 1);
    pin_in[0] = 1'b0; cyc(4);
    chk("R7 pending held", 32'(irq[0]), 1);
    wr(4'h8, 32'h1); @(negedge clk);
    chk("R7 cleared", 32'(irq[0]), 0);

    // R7 clear in the same cycle as a new edge: edge wins
    pin_in[0] = 1'b1;                // captured at edge A
    @(negedge clk);                  // after A
    @(negedge clk);                  // after B: detection cycle
    addr = 4'h8; we = 1'b1; wdata = 32'h1;
    @(negedge clk); we = 1'b0;       // after C
    chk("R7 edge beats clear", 32'(irq[0]), 1);

    // R7 clear one cycle after the edge: cleared
    wr(4'h8, 32'h1); pin_in[0] = 1'b0; cyc(4);
    pin_in[0] = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    addr = 4'h8; we = 1'b1; wdata = 32'h1;
    @(negedge clk); we = 1'b0;
    chk("R7 late clear", 32'(irq[0]), 0);

    // R8 disabled line does not latch pending
    wr(4'h4, 32'h0000_0002);         // line0 rising, disabled
    pin_in[0] = 1'b0; cyc(4);
    pin_in[0] = 1'b1; cyc(4);
    chk("R8 disabled irq", 32'(irq[0]), 0);
    wr(4'h4, 32'h0000_000A);         // enable, no new edge
    @(negedge clk);
    chk("R8 no latched pending", 32'(irq[0]), 0);

    finish_up();
  end
endmodule